// File: doc/BRIEF.md
# Eight-Input Priority Interrupt Controller

This block gathers eight interrupt request lines into one interrupt line toward a processor. It keeps a pending-request register, a mask register and an in-service register. A fixed-priority resolver picks the winning request: line 0 ranks highest and line 7 lowest. The interrupt line is raised only when that winner is unmasked and ranks strictly above every line already in service.

The processor answers with two acknowledge pulses. On the first pulse the block moves the winner from pending to in-service. During the second pulse the block drives an 8-bit type code, which is the five-bit base value from the initialization logic followed by the 3-bit line number. The mask register is loaded through a single write strobe. A non-specific end-of-interrupt strobe retires the highest-priority line that is in service. All inputs are synchronous to `clk`.

Top module: `prio_irq_ctrl`

## Requirements
- R1: When several eligible requests are pending, the one on the lowest-numbered line is served first (line 0 highest, line 7 lowest).
- R2: A mask bit of 1 blocks its line from raising `int_out`, and a bit of 0 lets it through. A masked request stays pending and is served once its mask bit is cleared.
- R3: A low-to-high transition on `irq_in[i]` sets pending bit i, seen at the clock edge that samples the transition. A line held high does not request again after it is served.
- R4: The rising edge of the first acknowledge pulse clears the winner's pending bit and sets its in-service bit, so that line cannot raise `int_out` again until a new edge arrives.
- R5: `int_out` is high, starting the cycle after the capturing edge, whenever an unmasked pending request passes the rank rule of R10.
- R6: `data_oe` is high only for the second acknowledge pulse. It rises the clock after that pulse's rising edge is sampled and falls the clock after its falling edge is sampled. `data_out` holds steady while `data_oe` is high.
- R7: Reset and `init_load` clear the mask, pending and in-service registers and return the acknowledge sequence to idle. `init_load` also loads `type_base`, and reset loads zero.
- R8: The type driven in the second pulse is {`type_base` (5 bits), winning line number (3 bits)}.
- R9: An `eoi` strobe clears only the lowest-numbered set in-service bit. It has no effect when no bit is set.
- R10: A pending request is eligible only if its line number is strictly less than that of every in-service line. A request on the line in service, or on a lower-ranked line, is held off.
- R11: If no request is eligible at the first pulse, nothing enters service, and the second pulse drives {`type_base`, 3'b111}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| init_load | input | 1 | Initialization strobe: clears state, loads type_base |
| type_base | input | 5 | Upper five bits of the type code |
| irq_in | input | 8 | Interrupt request lines, edge sensitive |
| mask_we | input | 1 | Mask register write strobe |
| mask_wdata | input | 8 | Mask value, 1 = blocked |
| eoi | input | 1 | Non-specific end-of-interrupt strobe |
| ack_in | input | 1 | Acknowledge pulses from the processor, active high |
| int_out | output | 1 | Interrupt request to the processor |
| data_out | output | 8 | Type code |
| data_oe | output | 1 | Bus drive enable; the pad is high-impedance when low |

## Verification
The hardest state to reach is nesting. A low-priority line must already be in service when a higher line breaks in. A fresh edge on the serviced line must also be waiting behind it. The stimulus acknowledges line 5 and then pulses line 5 again, which must not raise the interrupt. It then pulses line 1, acknowledges it, and issues two end-of-interrupt strobes. After the first strobe the interrupt must stay low, because line 5 is still in service. After the second it must rise. This shows that each strobe retires only the highest in-service line.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;
    localparam int IRQ_N  = 8;
    localparam int IDX_W  = $clog2(IRQ_N);
    localparam int TYPE_W = 8;
    localparam int BASE_W = TYPE_W - IDX_W;

    typedef logic [IRQ_N-1:0]  irq_vec_t;
    typedef logic [IDX_W-1:0]  irq_idx_t;
    typedef logic [TYPE_W-1:0] type_t;
    typedef logic [BASE_W-1:0] base_t;

    typedef enum logic [1:0] {
        ACK_IDLE  = 2'd0,
        ACK_WAIT2 = 2'd1,
        ACK_DRIVE = 2'd2
    } ack_state_e;

    // index of the lowest-numbered set bit (0 when none is set)
    function automatic irq_idx_t first_set(irq_vec_t v);
        irq_idx_t r;
        r = '0;
        for (int i = IRQ_N - 1; i >= 0; i--) begin
            if (v[i]) r = irq_idx_t'(i);
        end
        return r;
    endfunction

    function automatic irq_vec_t one_hot(irq_idx_t idx);
        return irq_vec_t'(1) << idx;
    endfunction
endpackage

// File: rtl/prio_irq_capture.sv
module prio_irq_capture
    import prio_irq_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     init_load,
    input  irq_vec_t irq_in,
    input  logic     clr_en,
    input  irq_idx_t clr_idx,
    output irq_vec_t req_o
);
    typedef struct packed {
        irq_vec_t prev;
        irq_vec_t req;
    } cap_t;

    cap_t cap_d, cap_q;
    irq_vec_t rise, clr;

    always_comb begin
        rise  = irq_in & ~cap_q.prev;
        clr   = clr_en ? one_hot(clr_idx) : '0;
        cap_d = cap_q;
        cap_d.prev = irq_in;
        cap_d.req  = (cap_q.req & ~clr) | rise;
        if (init_load) begin
            cap_d.req = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_q <= '0;
        end else begin
            cap_q <= cap_d;
        end
    end

    assign req_o = cap_q.req;

    AST_EDGE_SETS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (!init_load && !clr_en) |=> ((req_o & $past(irq_in & ~cap_q.prev)) == $past(irq_in & ~cap_q.prev))); // R3
endmodule

// File: rtl/prio_irq_resolve.sv
module prio_irq_resolve
    import prio_irq_pkg::*;
(
    input  irq_vec_t req,
    input  irq_vec_t mask,
    input  irq_vec_t isr,
    output logic     grant,
    output irq_idx_t win_idx
);
    irq_vec_t blocked;
    irq_vec_t cand;

    // a line is blocked when it or any higher-ranked line is in service
    for (genvar g = 0; g < IRQ_N; g++) begin : g_block
        assign blocked[g] = |isr[g:0];
    end

    always_comb begin
        cand    = req & ~mask & ~blocked;
        grant   = |cand;
        win_idx = first_set(cand);
    end
endmodule

// File: rtl/prio_irq_ack_seq.sv
module prio_irq_ack_seq
    import prio_irq_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     init_load,
    input  logic     ack_in,
    input  logic     grant,
    input  irq_idx_t win_idx,
    input  base_t    base,
    output logic     commit,
    output irq_idx_t commit_idx,
    output logic     data_oe,
    output type_t    data_out
);
    typedef struct packed {
        ack_state_e st;
        logic       ack_prev;
        irq_idx_t   sel;
        type_t      bus;
    } seq_t;

    seq_t seq_d, seq_q;
    logic ack_rise, ack_fall;

    always_comb begin
        ack_rise   = ack_in & ~seq_q.ack_prev;
        ack_fall   = ~ack_in & seq_q.ack_prev;
        seq_d      = seq_q;
        seq_d.ack_prev = ack_in;
        commit     = 1'b0;
        commit_idx = win_idx;
        unique case (seq_q.st)
            ACK_IDLE: begin
                if (ack_rise) begin
                    seq_d.st = ACK_WAIT2;
                    if (grant) begin
                        commit    = 1'b1;
                        seq_d.sel = win_idx;
                    end else begin
                        seq_d.sel = '1;
                    end
                end
            end
            ACK_WAIT2: begin
                if (ack_rise) begin
                    seq_d.st  = ACK_DRIVE;
                    seq_d.bus = {base, seq_q.sel};
                end
            end
            ACK_DRIVE: begin
                if (ack_fall) begin
                    seq_d.st  = ACK_IDLE;
                    seq_d.bus = '0;
                end
            end
            default: seq_d.st = ACK_IDLE;
        endcase
        if (init_load) begin
            commit    = 1'b0;
            seq_d.st  = ACK_IDLE;
            seq_d.sel = '0;
            seq_d.bus = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q <= '{st: ACK_IDLE, ack_prev: 1'b0, sel: '0, bus: '0};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign data_oe  = (seq_q.st == ACK_DRIVE);
    assign data_out = seq_q.bus;

    AST_OE_NEEDS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        data_oe |-> $past(ack_in)); // R6
    AST_BUS_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
        (data_oe && $past(data_oe)) |-> $stable(data_out)); // R6
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
    import prio_irq_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    init_load,
    input  logic [BASE_W-1:0]       type_base,
    input  logic [IRQ_N-1:0]        irq_in,
    input  logic                    mask_we,
    input  logic [IRQ_N-1:0]        mask_wdata,
    input  logic                    eoi,
    input  logic                    ack_in,
    output logic                    int_out,
    output logic [TYPE_W-1:0]       data_out,
    output logic                    data_oe
);
    typedef struct packed {
        irq_vec_t mask;
        irq_vec_t isr;
        base_t    base;
    } core_t;

    core_t    core_d, core_q;
    irq_vec_t req;
    logic     grant;
    irq_idx_t win_idx;
    logic     commit;
    irq_idx_t commit_idx;
    irq_vec_t eoi_clr, isr_set;

    prio_irq_capture u_capture (
        .clk       (clk),
        .rst_n     (rst_n),
        .init_load (init_load),
        .irq_in    (irq_in),
        .clr_en    (commit),
        .clr_idx   (commit_idx),
        .req_o     (req)
    );

    prio_irq_resolve u_resolve (
        .req     (req),
        .mask    (core_q.mask),
        .isr     (core_q.isr),
        .grant   (grant),
        .win_idx (win_idx)
    );

    prio_irq_ack_seq u_ack (
        .clk        (clk),
        .rst_n      (rst_n),
        .init_load  (init_load),
        .ack_in     (ack_in),
        .grant      (grant),
        .win_idx    (win_idx),
        .base       (core_q.base),
        .commit     (commit),
        .commit_idx (commit_idx),
        .data_oe    (data_oe),
        .data_out   (data_out)
    );

    always_comb begin
        core_d  = core_q;
        eoi_clr = (eoi && (core_q.isr != '0)) ? one_hot(first_set(core_q.isr)) : '0;
        isr_set = commit ? one_hot(commit_idx) : '0;
        core_d.isr = (core_q.isr & ~eoi_clr) | isr_set;
        if (mask_we) begin
            core_d.mask = mask_wdata;
        end
        if (init_load) begin
            core_d.mask = '0;
            core_d.isr  = '0;
            core_d.base = type_base;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            core_q <= '0;
        end else begin
            core_q <= core_d;
        end
    end

    assign int_out = grant;

    AST_COMMIT_SETS_ISR: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && !init_load) |=> core_q.isr[$past(commit_idx)]); // R4
    AST_EOI_CLEARS_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi && !commit && !init_load && core_q.isr != '0)
        |=> ($countones(core_q.isr) + 1 == $past($countones(core_q.isr)))); // R9
    AST_MASK_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_we && !init_load) |=> (core_q.mask == $past(mask_wdata))); // R2
    AST_INIT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        init_load |=> (core_q.mask == '0 && core_q.isr == '0 && !data_oe && !int_out)); // R7
endmodule

// File: tb/prio_irq_ctrl_test.sv
module prio_irq_ctrl_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       init_load = 1'b0;
    logic [4:0] type_base = 5'd0;
    logic [7:0] irq_in = 8'h00;
    logic       mask_we = 1'b0;
    logic [7:0] mask_wdata = 8'h00;
    logic       eoi = 1'b0;
    logic       ack_in = 1'b0;
    logic       int_out;
    logic [7:0] data_out;
    logic       data_oe;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    prio_irq_ctrl uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .init_load  (init_load),
        .type_base  (type_base),
        .irq_in     (irq_in),
        .mask_we    (mask_we),
        .mask_wdata (mask_wdata),
        .eoi        (eoi),
        .ack_in     (ack_in),
        .int_out    (int_out),
        .data_out   (data_out),
        .data_oe    (data_oe)
    );

    task automatic chk1(string tag, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %b expected %b", tag, act, exp);
        end
    endtask

    task automatic chk8(string tag, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic step(int n = 1);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_irq(logic [7:0] bits);
        irq_in = irq_in | bits;
        step();
        irq_in = irq_in & ~bits;
        step();
    endtask

    task automatic do_ack(output logic [7:0] vec);
        ack_in = 1'b1; step();
        chk1("R6 oe low in first pulse", data_oe, 1'b0);
        ack_in = 1'b0; step();
        chk1("R6 oe low between pulses", data_oe, 1'b0);
        ack_in = 1'b1; step();
        chk1("R6 oe high in second pulse", data_oe, 1'b1);
        vec = data_out;
        step();
        chk8("R6 bus steady", data_out, vec);
        ack_in = 1'b0; step();
        chk1("R6 oe low after second pulse", data_oe, 1'b0);
    endtask

    task automatic send_eoi();
        eoi = 1'b1; step();
        eoi = 1'b0; step();
    endtask

    task automatic write_mask(logic [7:0] m);
        mask_we = 1'b1; mask_wdata = m; step();
        mask_we = 1'b0; step();
    endtask

    task automatic do_init(logic [4:0] b);
        type_base = b; init_load = 1'b1; step();
        init_load = 1'b0; step();
    endtask

    task automatic t_reset();
        logic [7:0] v;
        chk1("R7 int low after reset", int_out, 1'b0);
        chk1("R7 oe low after reset", data_oe, 1'b0);
        do_ack(v);
        chk8("R7 R11 reset base zero, idle type", v, 8'h07);
    endtask

    task automatic t_single();
        logic [7:0] v;
        do_init(5'b01000);
        pulse_irq(8'h10);
        chk1("R5 int on edge of line 4", int_out, 1'b1);
        do_ack(v);
        chk8("R8 type for line 4", v, 8'h44);
        chk1("R4 request cleared after ack", int_out, 1'b0);
        send_eoi();
        chk1("R4 no re-request after eoi", int_out, 1'b0);
    endtask

    task automatic t_priority();
        logic [7:0] v;
        pulse_irq(8'h44);
        do_ack(v);
        chk8("R1 line 2 beats line 6", v, 8'h42);
        chk1("R10 line 6 held off by line 2", int_out, 1'b0);
        send_eoi();
        chk1("R9 line 6 freed by eoi", int_out, 1'b1);
        do_ack(v);
        chk8("R1 line 6 served second", v, 8'h46);
        send_eoi();
    endtask

    task automatic t_mask();
        logic [7:0] v;
        write_mask(8'h08);
        pulse_irq(8'h08);
        chk1("R2 masked line 3 quiet", int_out, 1'b0);
        write_mask(8'h00);
        chk1("R2 unmask releases pending", int_out, 1'b1);
        do_ack(v);
        chk8("R2 line 3 served", v, 8'h43);
        send_eoi();
    endtask

    task automatic t_edge();
        logic [7:0] v;
        irq_in[1] = 1'b1; step(2);
        chk1("R3 rising edge requests", int_out, 1'b1);
        do_ack(v);
        chk8("R3 line 1 served", v, 8'h41);
        send_eoi();
        step(3);
        chk1("R3 held level no new request", int_out, 1'b0);
        irq_in[1] = 1'b0; step();
    endtask

    task automatic t_nest();
        logic [7:0] v;
        pulse_irq(8'h20);
        do_ack(v);
        chk8("R10 line 5 in service", v, 8'h45);
        pulse_irq(8'h20);
        chk1("R10 same line not strictly higher", int_out, 1'b0);
        pulse_irq(8'h02);
        chk1("R10 line 1 breaks in", int_out, 1'b1);
        do_ack(v);
        chk8("R10 nested type", v, 8'h41);
        send_eoi();
        chk1("R9 eoi retires only line 1", int_out, 1'b0);
        send_eoi();
        chk1("R9 second eoi retires line 5", int_out, 1'b1);
        do_ack(v);
        chk8("R9 pending line 5 served", v, 8'h45);
        send_eoi();
        chk1("R9 all idle", int_out, 1'b0);
    endtask

    task automatic t_init();
        logic [7:0] v;
        write_mask(8'hF0);
        pulse_irq(8'h04);
        chk1("R7 pending before init", int_out, 1'b1);
        do_init(5'b10101);
        chk1("R7 init drops pending", int_out, 1'b0);
        pulse_irq(8'h80);
        chk1("R7 init cleared mask", int_out, 1'b1);
        pulse_irq(8'h01);
        do_ack(v);
        chk8("R8 new base with line 0", v, 8'hA8);
        send_eoi();
        do_ack(v);
        chk8("R8 new base with line 7", v, 8'hAF);
        send_eoi();
    endtask

    task automatic t_spurious();
        logic [7:0] v;
        do_init(5'b01000);
        send_eoi();
        do_ack(v);
        chk8("R11 no request gives line 7 code", v, 8'h47);
        chk1("R11 int stays low", int_out, 1'b0);
        pulse_irq(8'h80);
        chk1("R11 nothing entered service", int_out, 1'b1);
        do_ack(v);
        chk8("R11 line 7 served normally", v, 8'h47);
        send_eoi();
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        step(3);
        rst_n = 1'b1;
        step();
        t_reset();
        t_single();
        t_priority();
        t_mask();
        t_edge();
        t_nest();
        t_init();
        t_spurious();
        finish_run();
    end
endmodule